// File: doc/BRIEF.md
# Immediate Word Load/Store Unit

This unit executes the two descriptor commands that move a small immediate value between system memory and the 32-bit command-dependent word of the current descriptor. A sequencer hands it one command with a single-cycle `start` pulse. The command carries the direction, the address-space key, the request count, the memory address, the current immediate word and the descriptor pointer. The unit checks the key and derives the access width and the aligned address from the count. It then issues exactly one memory beat: a read for a load, a write for a store.

When the access completes, the unit reports a single outcome. The outcome is one of three: the channel is killed, the command is parked by a satisfied wait condition, or the command completes. A completed command means the descriptor is written back with the possibly updated immediate word, the flush indication is cleared, the interrupt condition is applied and the pointer moves to the next descriptor. Branching never happens for these commands, and fetching the next descriptor belongs to the sequencer.

Top module: `imw_unit`

## Requirements
- R1: The access width is set by the low three bits of `cmd_count` only, with bit 2 taking priority over bit 1. Bit 2 set gives 4 bytes, `bus_size`=2 and the address with bits [1:0] cleared. Otherwise bit 1 set gives 2 bytes, `bus_size`=1 and the address with bit 0 cleared. Otherwise the access is 1 byte, `bus_size`=0, at the unmodified address.
- R2: `bus_be` marks the byte lanes of the aligned address, with lane n meaning bits [8n+7:8n]. A 4-byte access gives 4'b1111. A 2-byte access gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A 1-byte access gives one bit, at the position set by address bits [1:0].
- R3: Bus data is right-justified. A store drives the whole immediate word for 4 bytes, the word shifted right by 16 for 2 bytes, and the word shifted right by 24 for 1 byte. All unused upper bits are zero.
- R4: Bus data for a load is right-justified. A 4-byte read replaces the immediate word. A 2-byte read (`bus_rdata[15:0]`) goes to bits [31:16] and keeps bits [15:0]. A 1-byte read (`bus_rdata[7:0]`) goes to bits [31:24] and keeps bits [23:0]. `wb_dep` shows the word held by the unit.
- R5: Keys 0 to 3 are replaced by the system-memory key 6, and key 6 proceeds. Keys 4, 5 and 7 kill the command. A killed command makes no bus request. One cycle after `start`, the unit raises `done` with `done_killed` and `irq`. At most one of `done_killed`, `done_parked` and `done_advance` is ever high.
- R6: `bus_req` rises in the cycle after `start`. It stays high, with address, size, lanes, direction and data unchanged, until the cycle in which `bus_ack` is sampled. `done` is high for exactly the one cycle that follows the ack.
- R7: In the `done` cycle, the wait mode decides whether the command parks. Mode 0 never parks, mode 3 always parks, mode 1 parks on a match and mode 2 parks on a miss. A match is `(cond_stat & wait_mask) == (wait_value & wait_mask)`. A parked command raises `done_parked`, gives no `irq` and leaves `next_ptr` equal to the command's pointer.
- R8: A command that is neither killed nor parked raises `done_advance`. This tells the sequencer to write back the descriptor with `wb_dep`, clear the flush indication and move on. `next_ptr` is the command's pointer plus 16, wrapping at the address width.
- R9: On a completing command, `irq` follows the interrupt mode, using the same mode encoding as R7 with `intr_mask` and `intr_value`.
- R10: `busy` is high from the cycle after an accepted `start` until the `done` cycle, inclusive. A `start` seen while `busy` is high is ignored.
- R11: After reset, `busy`, `bus_req`, `done` and `irq` are low, and `wb_dep` and `next_ptr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command valid pulse, taken only when idle |
| cmd_store | input | 1 | 1 = store the immediate word, 0 = load into it |
| cmd_key | input | 3 | Address-space key |
| cmd_count | input | CNT_W | Request count field |
| cmd_addr | input | ADDR_W | Memory address of the value |
| cmd_dep | input | 32 | Current immediate word |
| cmd_ptr | input | ADDR_W | Address of the current descriptor |
| wait_mode | input | 2 | Wait condition mode |
| intr_mode | input | 2 | Interrupt condition mode |
| cond_stat | input | COND_W | Device status bits tested by the conditions |
| wait_mask | input | COND_W | Wait condition select mask |
| wait_value | input | COND_W | Wait condition select value |
| intr_mask | input | COND_W | Interrupt condition select mask |
| intr_value | input | COND_W | Interrupt condition select value |
| busy | output | 1 | Command in progress |
| bus_req | output | 1 | Memory beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Aligned beat address |
| bus_size | output | 2 | Beat width code: 0 byte, 1 half, 2 word |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Right-justified write data |
| bus_rdata | input | 32 | Right-justified read data, valid with ack |
| bus_ack | input | 1 | Beat complete |
| done | output | 1 | Command outcome valid |
| done_killed | output | 1 | Channel killed by an unsupported key |
| done_parked | output | 1 | Wait condition satisfied, nothing advanced |
| done_advance | output | 1 | Write back, clear flush, advance |
| irq | output | 1 | Interrupt request |
| wb_dep | output | 32 | Immediate word for the descriptor writeback |
| next_ptr | output | ADDR_W | Descriptor pointer after the outcome |

## Verification
Faults in this block show up at the ports within a few cycles. A wrong decoded width or a wrong alignment mask shows on `bus_addr`, `bus_size` and `bus_be` in the very first request cycle, well before the beat completes. A lane-merge or shift fault stays hidden until `bus_ack` during a load, and shows on `wb_dep` one cycle later. A store fault shows on `bus_wdata` while the request is held. A bad condition or outcome decode shows only in the single `done` cycle, as the wrong outcome flag, a missing or spurious `irq`, or a `next_ptr` that has or has not moved by 16. For that reason the stimulus drives every wait and interrupt mode against both matching and missing status.

// File: rtl/imw_pkg.sv
package imw_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    localparam logic [2:0] KEY_SYSMEM = 3'd6;
    localparam logic [2:0] KEY_LOW_LIMIT = 3'd4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_FIN  = 2'd2,
        ST_KILL = 2'd3
    } unit_state_e;

    typedef enum logic [1:0] {
        CM_NEVER    = 2'd0,
        CM_ON_MATCH = 2'd1,
        CM_ON_MISS  = 2'd2,
        CM_ALWAYS   = 2'd3
    } cond_mode_e;

    typedef struct packed {
        logic       is_store;
        xfer_size_e size;
        cond_mode_e wait_mode;
        cond_mode_e intr_mode;
    } cmd_ctl_t;

    // Width from the three-bit count: bit 2 wins over bit 1.
    function automatic xfer_size_e size_of_count(input logic [2:0] cnt);
        if (cnt[2])
            return SZ_WORD;
        else if (cnt[1])
            return SZ_HALF;
        return SZ_BYTE;
    endfunction

    // Keys below the first device space fall back to system memory.
    function automatic logic [2:0] effective_key(input logic [2:0] key);
        return (key < KEY_LOW_LIMIT) ? KEY_SYSMEM : key;
    endfunction

    // Address bits cleared by the alignment of a given width.
    function automatic logic [1:0] align_drop(input xfer_size_e sz);
        case (sz)
            SZ_WORD: return 2'b11;
            SZ_HALF: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/imw_decode.sv
module imw_decode
    import imw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [2:0]        key,
    input  logic [2:0]        count,
    input  logic [ADDR_W-1:0] addr,
    output xfer_size_e        size,
    output logic [ADDR_W-1:0] addr_aligned,
    output logic [LANES-1:0]  lane_en,
    output logic              fatal
);

    logic [1:0] drop;

    always_comb begin
        size         = size_of_count(count);
        drop         = align_drop(size);
        addr_aligned = {addr[ADDR_W-1:2], addr[1:0] & ~drop};
        fatal        = (effective_key(key) != KEY_SYSMEM);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [1:0] LIDX = 2'(l);
        assign lane_en[l] = (size == SZ_WORD)
                          | ((size == SZ_HALF) & (LIDX[1] == addr_aligned[1]))
                          | ((size == SZ_BYTE) & (LIDX == addr_aligned[1:0]));
    end

endmodule

// File: rtl/imw_lanes.sv
module imw_lanes
    import imw_pkg::*;
(
    input  xfer_size_e        size,
    input  logic [WORD_W-1:0] dep,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] merged
);

    localparam int HALF_L = LANES / 2;

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        logic [7:0] dep_b;
        logic [7:0] rd_b;
        logic [7:0] st_half;
        logic [7:0] ld_half;
        logic [7:0] st_byte;
        logic [7:0] ld_byte;

        assign dep_b = dep[8*b +: 8];
        assign rd_b  = rdata[8*b +: 8];

        // Store data is right-justified; load data fills the top lanes.
        if (b < HALF_L) begin : g_low
            assign st_half = dep[8*(b+HALF_L) +: 8];
            assign ld_half = dep_b;
        end else begin : g_high
            assign st_half = 8'h00;
            assign ld_half = rdata[8*(b-HALF_L) +: 8];
        end

        if (b == 0) begin : g_first
            assign st_byte = dep[8*(LANES-1) +: 8];
        end else begin : g_rest_st
            assign st_byte = 8'h00;
        end

        if (b == LANES - 1) begin : g_top
            assign ld_byte = rdata[7:0];
        end else begin : g_rest_ld
            assign ld_byte = dep_b;
        end

        assign wdata[8*b +: 8]  = (size == SZ_WORD) ? dep_b :
                                  (size == SZ_HALF) ? st_half : st_byte;
        assign merged[8*b +: 8] = (size == SZ_WORD) ? rd_b :
                                  (size == SZ_HALF) ? ld_half : ld_byte;
    end

endmodule

// File: rtl/imw_cond.sv
module imw_cond
    import imw_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  cond_mode_e        mode,
    input  logic [COND_W-1:0] stat,
    input  logic [COND_W-1:0] sel_mask,
    input  logic [COND_W-1:0] sel_value,
    output logic              fire
);

    logic hit;

    always_comb begin
        hit = ((stat & sel_mask) == (sel_value & sel_mask));
        case (mode)
            CM_NEVER:    fire = 1'b0;
            CM_ON_MATCH: fire = hit;
            CM_ON_MISS:  fire = ~hit;
            default:     fire = 1'b1;
        endcase
    end

endmodule

// File: rtl/imw_unit.sv
module imw_unit
    import imw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int COND_W   = 4,
    parameter int CNT_W    = 16,
    parameter int PTR_STEP = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmd_store,
    input  logic [2:0]        cmd_key,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_dep,
    input  logic [ADDR_W-1:0] cmd_ptr,
    input  logic [1:0]        wait_mode,
    input  logic [1:0]        intr_mode,
    input  logic [COND_W-1:0] cond_stat,
    input  logic [COND_W-1:0] wait_mask,
    input  logic [COND_W-1:0] wait_value,
    input  logic [COND_W-1:0] intr_mask,
    input  logic [COND_W-1:0] intr_value,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [LANES-1:0]  bus_be,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic              done_killed,
    output logic              done_parked,
    output logic              done_advance,
    output logic              irq,
    output logic [WORD_W-1:0] wb_dep,
    output logic [ADDR_W-1:0] next_ptr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PTR_STEP);

    unit_state_e       state_q;
    cmd_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [WORD_W-1:0] dep_q;
    logic [ADDR_W-1:0] ptr_q;

    xfer_size_e        dec_size;
    logic [ADDR_W-1:0] dec_addr;
    logic [LANES-1:0]  dec_lanes;
    logic              dec_fatal;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] lane_merged;
    logic              wait_fire;
    logic              intr_fire;
    logic              unused_cnt;

    assign unused_cnt = ^cmd_count[CNT_W-1:3];

    imw_decode #(.ADDR_W(ADDR_W)) u_decode (
        .key          (cmd_key),
        .count        (cmd_count[2:0]),
        .addr         (cmd_addr),
        .size         (dec_size),
        .addr_aligned (dec_addr),
        .lane_en      (dec_lanes),
        .fatal        (dec_fatal)
    );

    imw_lanes u_lanes (
        .size   (ctl_q.size),
        .dep    (dep_q),
        .rdata  (bus_rdata),
        .wdata  (lane_wdata),
        .merged (lane_merged)
    );

    imw_cond #(.COND_W(COND_W)) u_wait_cond (
        .mode      (ctl_q.wait_mode),
        .stat      (cond_stat),
        .sel_mask  (wait_mask),
        .sel_value (wait_value),
        .fire      (wait_fire)
    );

    imw_cond #(.COND_W(COND_W)) u_intr_cond (
        .mode      (ctl_q.intr_mode),
        .stat      (cond_stat),
        .sel_mask  (intr_mask),
        .sel_value (intr_value),
        .fire      (intr_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            dep_q   <= '0;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctl_q   <= '{is_store:  cmd_store,
                                     size:      dec_size,
                                     wait_mode: cond_mode_e'(wait_mode),
                                     intr_mode: cond_mode_e'(intr_mode)};
                        addr_q  <= dec_addr;
                        be_q    <= dec_lanes;
                        dep_q   <= cmd_dep;
                        ptr_q   <= cmd_ptr;
                        state_q <= dec_fatal ? ST_KILL : ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        if (!ctl_q.is_store)
                            dep_q <= lane_merged;
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy         = (state_q != ST_IDLE);
        bus_req      = (state_q == ST_BUS);
        bus_we       = ctl_q.is_store;
        bus_addr     = addr_q;
        bus_size     = ctl_q.size;
        bus_be       = be_q;
        bus_wdata    = lane_wdata;
        done         = (state_q == ST_FIN) || (state_q == ST_KILL);
        done_killed  = (state_q == ST_KILL);
        done_parked  = (state_q == ST_FIN) && wait_fire;
        done_advance = (state_q == ST_FIN) && !wait_fire;
        irq          = done_killed || (done_advance && intr_fire);
        wb_dep       = dep_q;
        next_ptr     = done_advance ? (ptr_q + STEP) : ptr_q;
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_wdata) && $stable(bus_we))); // R6

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (done && !done_killed && !bus_req)); // R6

    AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ((bus_size == 2'd2 && bus_addr[1:0] == 2'b00)
                  || (bus_size == 2'd1 && !bus_addr[0])
                  || (bus_size == 2'd0))); // R1

    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ($countones(bus_be) == (32'd1 << bus_size))); // R2

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_killed, done_parked, done_advance})); // R5

    AST_PARK_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_parked |-> !irq); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(bus_addr) && $stable(wb_dep) || $past(bus_req && bus_ack))); // R10

endmodule

// File: tb/imw_unit_tb.sv
module imw_unit_tb;

    logic        clk;
    logic        rst;
    logic        start;
    logic        cmd_store;
    logic [2:0]  cmd_key;
    logic [15:0] cmd_count;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_dep;
    logic [31:0] cmd_ptr;
    logic [1:0]  wait_mode;
    logic [1:0]  intr_mode;
    logic [3:0]  cond_stat;
    logic [3:0]  wait_mask;
    logic [3:0]  wait_value;
    logic [3:0]  intr_mask;
    logic [3:0]  intr_value;
    logic        busy;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        done;
    logic        done_killed;
    logic        done_parked;
    logic        done_advance;
    logic        irq;
    logic [31:0] wb_dep;
    logic [31:0] next_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int          m_st;
    bit          m_we;
    int          m_bytes;
    logic [31:0] m_addr;
    logic [31:0] m_dep;
    logic [31:0] m_ptr;
    logic [3:0]  m_be;
    logic [1:0]  m_wm;
    logic [1:0]  m_im;

    // bus responder control
    int          ack_lat;
    int          lat_cnt;
    logic [31:0] rd_val;

    imw_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .cmd_store(cmd_store), .cmd_key(cmd_key),
        .cmd_count(cmd_count), .cmd_addr(cmd_addr), .cmd_dep(cmd_dep), .cmd_ptr(cmd_ptr),
        .wait_mode(wait_mode), .intr_mode(intr_mode), .cond_stat(cond_stat),
        .wait_mask(wait_mask), .wait_value(wait_value), .intr_mask(intr_mask),
        .intr_value(intr_value), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done), .done_killed(done_killed),
        .done_parked(done_parked), .done_advance(done_advance), .irq(irq),
        .wb_dep(wb_dep), .next_ptr(next_ptr)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit cond_eval(input logic [1:0] mode, input logic [3:0] st,
                                     input logic [3:0] mask, input logic [3:0] val);
        bit match;
        match = ((st & mask) == (val & mask));
        case (mode)
            2'd0: return 1'b0;
            2'd1: return match;
            2'd2: return !match;
            default: return 1'b1;
        endcase
    endfunction

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_we = 0; m_bytes = 1; m_addr = 0; m_dep = 0; m_ptr = 0;
            m_be = 0; m_wm = 0; m_im = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    int k;
                    k = (cmd_key < 3'd4) ? 6 : int'(cmd_key);
                    if (cmd_count[2]) m_bytes = 4;
                    else if (cmd_count[1]) m_bytes = 2;
                    else m_bytes = 1;
                    m_addr = cmd_addr & ~(32'(m_bytes) - 32'd1);
                    if (m_bytes == 4) m_be = 4'hF;
                    else if (m_bytes == 2) m_be = m_addr[1] ? 4'hC : 4'h3;
                    else m_be = 4'(1 << m_addr[1:0]);
                    m_we = cmd_store; m_dep = cmd_dep; m_ptr = cmd_ptr;
                    m_wm = wait_mode; m_im = intr_mode;
                    m_st = (k != 6) ? 3 : 1;
                end
                1: if (bus_ack) begin
                    if (!m_we) begin
                        if (m_bytes == 4) m_dep = bus_rdata;
                        else if (m_bytes == 2) m_dep = {bus_rdata[15:0], m_dep[15:0]};
                        else m_dep = {bus_rdata[7:0], m_dep[23:0]};
                    end
                    m_st = 2;
                end
                default: m_st = 0;
            endcase
        end
    end

    // cycle compare, away from the edges
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            bit wh, adv;
            logic [31:0] exp_wd;
            chk("R10", "busy", 32'(busy), 32'(m_st != 0));
            chk("R6", "bus_req", 32'(bus_req), 32'(m_st == 1));
            if (m_st == 1) begin
                chk("R1", "bus_addr", bus_addr, m_addr);
                chk("R1", "bus_size", 32'(bus_size), (m_bytes == 4) ? 32'd2 : (m_bytes == 2) ? 32'd1 : 32'd0);
                chk("R2", "bus_be", 32'(bus_be), 32'(m_be));
                chk("R6", "bus_we", 32'(bus_we), 32'(m_we));
                if (m_we) begin
                    exp_wd = (m_bytes == 4) ? m_dep : (m_bytes == 2) ? (m_dep >> 16) : (m_dep >> 24);
                    chk("R3", "bus_wdata", bus_wdata, exp_wd);
                end
            end
            wh  = (m_st == 2) && cond_eval(m_wm, cond_stat, wait_mask, wait_value);
            adv = (m_st == 2) && !wh;
            chk("R6", "done", 32'(done), 32'(m_st >= 2));
            chk("R5", "done_killed", 32'(done_killed), 32'(m_st == 3));
            chk("R7", "done_parked", 32'(done_parked), 32'(wh));
            chk("R8", "done_advance", 32'(done_advance), 32'(adv));
            chk("R9", "irq", 32'(irq),
                32'((m_st == 3) || (adv && cond_eval(m_im, cond_stat, intr_mask, intr_value))));
            chk("R8", "next_ptr", next_ptr, adv ? m_ptr + 32'd16 : m_ptr);
            chk("R4", "wb_dep", wb_dep, m_dep);
        end
    end

    // single-beat memory responder
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0; lat_cnt = 0;
        end else if (bus_req && !bus_ack) begin
            if (lat_cnt >= ack_lat) begin
                bus_ack = 1'b1; bus_rdata = rd_val;
            end else begin
                lat_cnt++;
            end
        end else begin
            bus_ack = 1'b0; lat_cnt = 0;
        end
    end

    task automatic run_cmd(input bit st, input logic [2:0] key, input logic [15:0] cnt,
                           input logic [31:0] addr, input logic [31:0] dep,
                           input logic [31:0] ptr, input logic [1:0] wm, input logic [1:0] im,
                           input logic [3:0] stat, input logic [3:0] wmask, input logic [3:0] wval,
                           input logic [3:0] imask, input logic [3:0] ival,
                           input int lat, input logic [31:0] rd, input bit poke);
        @(negedge clk);
        cmd_store = st; cmd_key = key; cmd_count = cnt; cmd_addr = addr; cmd_dep = dep;
        cmd_ptr = ptr; wait_mode = wm; intr_mode = im; cond_stat = stat;
        wait_mask = wmask; wait_value = wval; intr_mask = imask; intr_value = ival;
        ack_lat = lat; rd_val = rd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: a second start while busy must be ignored
            start = 1'b1; cmd_addr = ~addr; cmd_dep = ~dep; cmd_key = 3'd5;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; cmd_store = 0; cmd_key = 3'd6; cmd_count = 0;
        cmd_addr = 0; cmd_dep = 0; cmd_ptr = 0; wait_mode = 0; intr_mode = 0;
        cond_stat = 0; wait_mask = 0; wait_value = 0; intr_mask = 0; intr_value = 0;
        bus_rdata = 0; bus_ack = 0; ack_lat = 0; rd_val = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #3;
        // R11 reset state
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "bus_req", 32'(bus_req), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "irq", 32'(irq), 32'd0);
        chk("R11", "wb_dep", wb_dep, 32'd0);
        chk("R11", "next_ptr", next_ptr, 32'd0);

        // stores, R1 R2 R3
        run_cmd(1, 3'd6, 16'h0004, 32'h2000_0007, 32'hA1B2_C3D4, 32'h0000_1000, 0, 3, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        run_cmd(1, 3'd0, 16'h0002, 32'h2000_0013, 32'hA1B2_C3D4, 32'h0000_1010, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0, 0);
        run_cmd(1, 3'd3, 16'h0000, 32'h2000_0021, 32'hA1B2_C3D4, 32'h0000_1020, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'hFFF9, 32'h2000_0022, 32'h5E6F_7081, 32'h0000_1030, 0, 0, 0, 0, 0, 0, 0, 2, 32'h0, 0);
        run_cmd(1, 3'd1, 16'h0006, 32'h2000_000B, 32'h0BAD_F00D, 32'h0000_1040, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        // loads, R4
        run_cmd(0, 3'd6, 16'h0004, 32'h3000_0000, 32'hFFFF_FFFF, 32'h0000_2000, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1122_3344, 0);
        run_cmd(0, 3'd2, 16'h0003, 32'h3000_0016, 32'hCAFE_F00D, 32'h0000_2010, 0, 0, 0, 0, 0, 0, 0, 0, 32'hDEAD_5566, 0);
        run_cmd(0, 3'd6, 16'h0001, 32'h3000_0033, 32'h0123_4567, 32'h0000_2020, 0, 0, 0, 0, 0, 0, 0, 2, 32'hFFFF_FF9A, 0);
        // kills, R5
        run_cmd(1, 3'd4, 16'h0004, 32'h4000_0000, 32'h1, 32'h0000_3000, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        run_cmd(0, 3'd5, 16'h0004, 32'h4000_0000, 32'h2, 32'h0000_3010, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 1);
        run_cmd(1, 3'd7, 16'h0002, 32'h4000_0002, 32'h3, 32'h0000_3020, 0, 3, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        // wait modes, R7
        run_cmd(1, 3'd6, 16'h0004, 32'h5000_0000, 32'h44, 32'h0000_4000, 3, 3, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h5000_0004, 32'h45, 32'h0000_4010, 1, 3, 4'h5, 4'hF, 4'h5, 0, 0, 1, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h5000_0008, 32'h46, 32'h0000_4020, 1, 2, 4'h4, 4'hF, 4'h5, 4'hF, 4'h5, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h5000_000C, 32'h47, 32'h0000_4030, 2, 3, 4'h4, 4'hF, 4'h5, 0, 0, 0, 32'h0, 0);
        run_cmd(0, 3'd6, 16'h0002, 32'h5000_0012, 32'h8765_4321, 32'h0000_4040, 3, 0, 0, 0, 0, 0, 0, 3, 32'h0000_ABCD, 0);
        // interrupt modes, R9
        run_cmd(1, 3'd6, 16'h0004, 32'h6000_0000, 32'h51, 32'h0000_5000, 0, 1, 4'h5, 0, 0, 4'h3, 4'h1, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h6000_0000, 32'h52, 32'h0000_5010, 0, 1, 4'h6, 0, 0, 4'h3, 4'h1, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h6000_0000, 32'h53, 32'h0000_5020, 0, 2, 4'h6, 0, 0, 4'h3, 4'h1, 0, 32'h0, 0);
        run_cmd(1, 3'd6, 16'h0004, 32'h6000_0000, 32'h54, 32'h0000_5030, 0, 0, 4'h5, 0, 0, 4'h3, 4'h1, 0, 32'h0, 0);
        // pointer wrap, R8
        run_cmd(1, 3'd6, 16'h0004, 32'h7000_0000, 32'h61, 32'hFFFF_FFF0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);
        // start while busy, R10
        run_cmd(0, 3'd6, 16'h0001, 32'h7000_0001, 32'h7777_7777, 32'h0000_6000, 0, 3, 0, 0, 0, 0, 0, 3, 32'h0000_00EE, 1);
        run_cmd(1, 3'd6, 16'h0002, 32'h7000_0002, 32'h1357_9BDF, 32'h0000_6010, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule